// File: doc/BRIEF.md
# Dual-Mode SPI NOR Flash Port

This block sits between a word-wide CPU bus and an external SPI NOR flash. After reset it answers CPU reads inside a 16 MiB window by running a standard flash read on chip select 0. It sends the read command and a 24-bit address, gathers 32 data bits and hands the word back with a one-cycle ready pulse. Out of reset, only the lowest 4 MiB of flash is reachable, and it appears four times across the window. This lets a boot vector near the top of the window land on flash offset zero. A control bit lifts the aliasing so that the window maps the full flash linearly.

Any store to the function-select word switches the block into register mode, where it stays until reset. In this mode, software drives every pin itself through an I/O register: three active-low chip selects, the clock level and the data-out bit. The only hardware help is a 32-bit receive shift register. It takes in one MISO bit each time a store to the I/O register raises the clock. Only SPI mode 3 exists: the clock idles high and both sides sample on the rising edge.

Top module: `sfi_dual_port`

## Requirements
- R1: After reset the block is in mapped mode with remap-disable cleared, all three chip-select outputs are high, the clock output is high, and bus_ready is low.
- R2: A mapped-mode read pulls only chip select 0 low, clocks at half the system clock rate (each bit is one low and one high system cycle), and sends the byte 0x03 and then the 24-bit flash address, most significant bit first, with data changing while the clock is low.
- R3: After the 64th rising clock edge of a mapped read, the block returns the 32 bits that followed the address, with the first received bit in bit 31. bus_ready is high for exactly one cycle, 129 cycles after the request is taken, and chip select 0 is high again from that cycle on.
- R4: With remap-disable clear, the flash address is the window address with bits 23:22 forced to zero, so window offsets 0x000020, 0x400020 and 0xC00010 reach flash offsets 0x000020, 0x000020 and 0x000010.
- R5: The control word at offset 0x4 holds remap-disable in bit 0. It can be written in both modes and reads back in register mode. When it is set, the window address is used unchanged as the flash address.
- R6: A write of any value to offset 0x0 selects register mode, which only reset leaves. In register mode, reads of offset 0x0 return zero.
- R7: In register mode the I/O word at offset 0x8 drives the pins: bit 0 is MOSI, bit 8 is the clock level, and bits 16, 17 and 18 are the levels of chip selects 0, 1 and 2. It reads back with all other bits zero, and its reset value is 0x00070100.
- R8: The read-data word at offset 0xC (reset value 0) shifts left by one and loads MISO into bit 0 only on an I/O write that moves the clock bit from 0 to 1. Any other write leaves it unchanged.
- R9: In mapped mode, writes to offsets 0x8 and 0xC change no pin, and a bus request that arrives while a mapped read is in progress is dropped without effect.
- R10: Every access other than a mapped-mode read completes with bus_ready high for one cycle in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
Two functions can fall into the same cycle: a bus request can arrive while a mapped flash read is still shifting. The bench sends a control-word write in the middle of a running read. It then checks that the read still returns the correct word from the alias-free address it started with, and that the control bit read back later keeps its old value. A second overlap sits inside register mode: an I/O write can both drive a new clock level and decide whether the receive register shifts. The bench repeats a clock-high write and checks that the captured byte does not move.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
    localparam int ADDR_W   = 24;
    localparam int WORD_W   = 32;
    localparam int CMD_W    = 8;
    localparam int CS_NUM   = 3;
    localparam int BOOT_W   = 22;
    localparam logic [CMD_W-1:0] CMD_READ = 8'h03;

    localparam int IO_MOSI_BIT = 0;
    localparam int IO_SCLK_BIT = 8;
    localparam int IO_CS_LSB   = 16;

    localparam logic [1:0] OFS_FSEL = 2'd0;
    localparam logic [1:0] OFS_CTRL = 2'd1;
    localparam logic [1:0] OFS_IO   = 2'd2;
    localparam logic [1:0] OFS_RXD  = 2'd3;

    typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_DONE} rd_state_t;

    typedef struct packed {
        logic [CS_NUM-1:0] cs_n;
        logic              sclk;
        logic              mosi;
    } pin_set_t;

    function automatic logic [ADDR_W-1:0] flash_addr(input logic [ADDR_W-1:0] win,
                                                      input logic remap_off);
        logic [ADDR_W-1:0] r;
        r = win;
        if (!remap_off) r[ADDR_W-1:BOOT_W] = '0;
        return r;
    endfunction
endpackage

// File: rtl/sfi_map_reader.sv
module sfi_map_reader
    import sfi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] faddr,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output pin_set_t          pins
);
    localparam int XFER_BITS = CMD_W + ADDR_W + WORD_W;
    localparam int CNT_W     = $clog2(XFER_BITS);
    localparam int TX_W      = CMD_W + ADDR_W;

    rd_state_t         st_q;
    logic [TX_W-1:0]   tx_q;
    logic [WORD_W-1:0] rx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RD_IDLE;
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
            hi_q  <= 1'b0;
        end else begin
            case (st_q)
                RD_IDLE: if (start) begin
                    tx_q  <= {CMD_READ, faddr};
                    cnt_q <= '0;
                    hi_q  <= 1'b0;
                    st_q  <= RD_SHIFT;
                end
                RD_SHIFT: begin
                    if (!hi_q) begin
                        hi_q <= 1'b1;
                    end else begin
                        hi_q <= 1'b0;
                        rx_q <= {rx_q[WORD_W-2:0], miso};
                        tx_q <= {tx_q[TX_W-2:0], 1'b0};
                        if (cnt_q == CNT_W'(XFER_BITS - 1)) st_q <= RD_DONE;
                        else cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= RD_IDLE;
            endcase
        end
    end

    always_comb begin
        pins.cs_n    = '1;
        pins.cs_n[0] = (st_q != RD_SHIFT);
        pins.sclk    = !((st_q == RD_SHIFT) && !hi_q);
        pins.mosi    = (st_q == RD_SHIFT) ? tx_q[TX_W-1] : 1'b0;
    end

    assign busy  = (st_q != RD_IDLE);
    assign done  = (st_q == RD_DONE);
    assign rdata = rx_q;

    // R3: completion lasts a single cycle
    p_ready_single_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R2: clock toggles every system cycle while shifting
    p_half_rate_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == RD_SHIFT && !hi_q) |=> pins.sclk);
    // R2: data bit holds steady across the high phase
    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == RD_SHIFT && !hi_q) |=> $stable(pins.mosi));
endmodule

// File: rtl/sfi_bang_regs.sv
module sfi_bang_regs
    import sfi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_io,
    input  logic [WORD_W-1:0] wdata,
    input  logic              miso,
    output pin_set_t          pins,
    output logic [WORD_W-1:0] io_word,
    output logic [WORD_W-1:0] rx_word
);
    pin_set_t          io_q;
    logic [WORD_W-1:0] sh_q;
    logic              rise;

    assign rise = wr_io && wdata[IO_SCLK_BIT] && !io_q.sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            io_q.cs_n <= '1;
            io_q.sclk <= 1'b1;
            io_q.mosi <= 1'b0;
            sh_q      <= '0;
        end else begin
            if (wr_io) begin
                io_q.cs_n <= wdata[IO_CS_LSB +: CS_NUM];
                io_q.sclk <= wdata[IO_SCLK_BIT];
                io_q.mosi <= wdata[IO_MOSI_BIT];
            end
            if (rise) sh_q <= {sh_q[WORD_W-2:0], miso};
        end
    end

    always_comb begin
        io_word = '0;
        io_word[IO_CS_LSB +: CS_NUM] = io_q.cs_n;
        io_word[IO_SCLK_BIT]         = io_q.sclk;
        io_word[IO_MOSI_BIT]         = io_q.mosi;
    end

    assign pins    = io_q;
    assign rx_word = sh_q;

    // R8: a raised clock shifts in MISO
    p_shift_in_r8: assert property (@(posedge clk) disable iff (rst)
        rise |=> rx_word == {$past(sh_q[WORD_W-2:0]), $past(miso)});
    // R8: no raise, no shift
    p_shift_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(rx_word));
endmodule

// File: rtl/sfi_dual_port.sv
module sfi_dual_port
    import sfi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [23:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [2:0]        spi_cs_n
);
    logic              reg_mode_q, remap_q;
    logic              ack_q;
    logic [WORD_W-1:0] ack_data_q;
    logic              eng_busy, eng_done;
    logic [WORD_W-1:0] eng_data, io_word, rx_word;
    pin_set_t          eng_pins, io_pins, out_pins;
    logic              take, map_rd, simple, wr_io, wr_fsel, wr_ctrl;
    logic              low_word;
    logic [1:0]        ofs;

    assign take     = bus_req && !eng_busy;
    assign map_rd   = take && !reg_mode_q && !bus_we;
    assign simple   = take && !map_rd;
    assign ofs      = bus_addr[3:2];
    assign low_word = (bus_addr[ADDR_W-1:4] == '0);
    assign wr_fsel  = simple && bus_we && (ofs == OFS_FSEL) && (reg_mode_q || low_word);
    assign wr_ctrl  = simple && bus_we && (ofs == OFS_CTRL) && (reg_mode_q || low_word);
    assign wr_io    = simple && bus_we && (ofs == OFS_IO) && reg_mode_q;

    sfi_map_reader u_rd (
        .clk(clk), .rst(rst), .start(map_rd),
        .faddr(flash_addr(bus_addr, remap_q)), .miso(spi_miso),
        .busy(eng_busy), .done(eng_done), .rdata(eng_data), .pins(eng_pins)
    );

    sfi_bang_regs u_io (
        .clk(clk), .rst(rst), .wr_io(wr_io), .wdata(bus_wdata), .miso(spi_miso),
        .pins(io_pins), .io_word(io_word), .rx_word(rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_mode_q <= 1'b0;
            remap_q    <= 1'b0;
            ack_q      <= 1'b0;
            ack_data_q <= '0;
        end else begin
            ack_q      <= simple;
            ack_data_q <= '0;
            if (wr_fsel) reg_mode_q <= 1'b1;
            if (wr_ctrl) remap_q    <= bus_wdata[0];
            if (simple && !bus_we && reg_mode_q) begin
                case (ofs)
                    OFS_CTRL: ack_data_q <= WORD_W'(remap_q);
                    OFS_IO:   ack_data_q <= io_word;
                    OFS_RXD:  ack_data_q <= rx_word;
                    default:  ack_data_q <= '0;
                endcase
            end
        end
    end

    assign out_pins  = reg_mode_q ? io_pins : eng_pins;
    assign spi_cs_n  = out_pins.cs_n;
    assign spi_sclk  = out_pins.sclk;
    assign spi_mosi  = out_pins.mosi;
    assign bus_ready = ack_q || eng_done;
    assign bus_rdata = eng_done ? eng_data : ack_data_q;

    // R6: register mode is left only by reset
    p_mode_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        reg_mode_q |=> reg_mode_q);
    // R2: mapped mode never touches chip selects 1 and 2
    p_cs_upper_r2: assert property (@(posedge clk) disable iff (rst)
        !reg_mode_q |-> spi_cs_n[2:1] == 2'b11);
    // R10: short accesses answer on the next cycle
    p_short_ack_r10: assert property (@(posedge clk) disable iff (rst)
        simple |=> bus_ready);
    // R9: a read in progress keeps the control bit
    p_busy_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && !eng_done) |=> $stable(remap_q));
endmodule

// File: tb/sim_sfi_dual_port.sv
module sim_sfi_dual_port;
    logic        clk = 1'b0, rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready, spi_sclk, spi_mosi, spi_miso;
    logic [2:0]  spi_cs_n;
    logic        tb_miso = 1'b0, m_miso = 1'b0;
    int          errors = 0, checks = 0, bad_cs = 0;
    bit          watch_map = 1'b0;
    int          m_cnt = 0;
    logic [31:0] m_cap = '0;

    always #5 clk = ~clk;

    sfi_dual_port u0 (.*);

    assign spi_miso = !spi_cs_n[0] ? m_miso : tb_miso;

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction
    function automatic logic [31:0] fword(input logic [23:0] a);
        return {fbyte(a), fbyte(a + 24'd1), fbyte(a + 24'd2), fbyte(a + 24'd3)};
    endfunction

    // flash model, mode 3, responds on chip select 0
    always @(negedge spi_cs_n[0]) m_cnt <= 0;
    always @(posedge spi_sclk) if (!spi_cs_n[0]) begin
        if (m_cnt < 32) m_cap <= {m_cap[30:0], spi_mosi};
        m_cnt <= m_cnt + 1;
    end
    always @(negedge spi_sclk) if (!spi_cs_n[0] && m_cnt >= 32) begin
        int k;
        k = m_cnt - 32;
        m_miso <= fbyte(m_cap[23:0] + 24'(k / 8))[7 - (k % 8)];
    end

    always @(negedge clk) if (watch_map && spi_cs_n[2:1] != 2'b11) bad_cs++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [23:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        lat = 1;
        while (!bus_ready && lat < 400) begin @(negedge clk); lat++; end
        rd = bus_rdata;
    endtask

    task automatic t_reset();
        chk("R1 cs", 32'(spi_cs_n), 32'h7);
        chk("R1 sclk", 32'(spi_sclk), 32'h1);
        chk("R1 ready", 32'(bus_ready), 32'h0);
    endtask

    task automatic t_boot_read();
        logic [31:0] rd; int lat;
        watch_map = 1'b1;
        access(1'b0, 24'hC00010, '0, rd, lat);
        chk("R2 command", 32'(m_cap[31:24]), 32'h03);
        chk("R4 alias C00010", 32'(m_cap[23:0]), 32'h000010);
        chk("R3 data", rd, fword(24'h000010));
        chk("R3 latency", 32'(lat), 32'd129);
        chk("R3 cs0 high", 32'(spi_cs_n), 32'h7);
        @(negedge clk);
        chk("R3 ready single", 32'(bus_ready), 32'h0);
        access(1'b0, 24'h400020, '0, rd, lat);
        chk("R4 alias 400020", 32'(m_cap[23:0]), 32'h000020);
        chk("R4 data", rd, fword(24'h000020));
        chk("R2 upper cs idle", 32'(bad_cs), 32'h0);
    endtask

    task automatic t_remap_and_collision();
        logic [31:0] rd; int lat;
        access(1'b1, 24'h000004, 32'h1, rd, lat);
        chk("R10 ctrl write latency", 32'(lat), 32'd1);
        fork
            access(1'b0, 24'hC00010, '0, rd, lat);
            begin
                repeat (20) @(negedge clk);
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = 24'h4; bus_wdata = 32'h0;
                @(negedge clk);
                bus_req = 1'b0;
            end
        join
        chk("R5 linear address", 32'(m_cap[23:0]), 32'hC00010);
        chk("R9 read survives collision", rd, fword(24'hC00010));
        access(1'b1, 24'h000008, 32'h0, rd, lat);
        @(negedge clk);
        chk("R9 io write ignored cs", 32'(spi_cs_n), 32'h7);
        chk("R9 io write ignored sclk", 32'(spi_sclk), 32'h1);
        watch_map = 1'b0;
    endtask

    task automatic t_regmode();
        logic [31:0] rd; int lat;
        access(1'b1, 24'h000000, 32'h1, rd, lat);
        access(1'b0, 24'h000004, '0, rd, lat);
        chk("R9 ctrl kept after collision", rd, 32'h1);
        chk("R10 read latency", 32'(lat), 32'd1);
        access(1'b0, 24'h000000, '0, rd, lat);
        chk("R6 fsel reads zero", rd, 32'h0);
        access(1'b0, 24'h000008, '0, rd, lat);
        chk("R7 io reset value", rd, 32'h00070100);
        access(1'b0, 24'h00000C, '0, rd, lat);
        chk("R8 rx reset value", rd, 32'h0);
    endtask

    task automatic t_bitbang();
        logic [31:0] rd; int lat;
        logic [7:0] tx = 8'hB4, rxp = 8'h3C;
        for (int j = 7; j >= 0; j--) begin
            tb_miso = rxp[j];
            access(1'b1, 24'h000008, 32'h00050000 | 32'(tx[j]), rd, lat);
            if (j == 5) begin
                chk("R7 mosi", 32'(spi_mosi), 32'(tx[j]));
                chk("R7 sclk low", 32'(spi_sclk), 32'h0);
                chk("R7 cs1 low", 32'(spi_cs_n), 32'h5);
            end
            access(1'b1, 24'h000008, 32'h00050100 | 32'(tx[j]), rd, lat);
        end
        access(1'b0, 24'h00000C, '0, rd, lat);
        chk("R8 captured byte", rd, 32'h3C);
        tb_miso = 1'b1;
        access(1'b1, 24'h000008, 32'h00050100, rd, lat);
        access(1'b0, 24'h00000C, '0, rd, lat);
        chk("R8 no shift without rise", rd, 32'h3C);
        access(1'b1, 24'h000000, 32'h0, rd, lat);
        access(1'b0, 24'h000008, '0, rd, lat);
        chk("R6 still register mode", rd, 32'h00050100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_boot_read();
        t_remap_and_collision();
        t_regmode();
        t_bitbang();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule